// File: doc/BRIEF.md
# Key-Armed Machine-Cycle Watchdog

This block guards a microcontroller core against runaway software. It comes out of hardware reset switched off and stays off until software writes a two-byte unlock key to one special-function address. The first complete key switches it on. Every later complete key services it by clearing its count. Once on, software cannot switch it off. While running, a 14-bit counter advances on each machine-cycle tick. When that counter wraps, the block raises a reset pulse of fixed length and then returns to the off state.

Counting follows the core's low-power state. In power-down the count is held. If power-down ends while the external wake interrupt line is still low, the count stays held until that line goes high. In idle the count keeps running by default. When the idle-freeze configuration bit is set, the count is held for as long as idle lasts.

The control state machine has five states:
- `WD_OFF` is the state after reset.
- `WD_RUN` counts.
- `WD_PDOWN` holds the count during power-down.
- `WD_WAKE` waits for the wake line to rise.
- `WD_FIRE` drives the reset pulse.

The transitions are:
- arm: `WD_OFF`→`WD_RUN` on a completed key.
- sleep: `WD_RUN`→`WD_PDOWN` when power-down is asserted.
- resume: `WD_PDOWN`→`WD_RUN` when power-down ends with the wake line high.
- wake-hold: `WD_PDOWN`→`WD_WAKE` when power-down ends with the wake line low.
- release: `WD_WAKE`→`WD_RUN` when the wake line rises.
- trip: `WD_RUN`→`WD_FIRE` when the counter wraps.
- expire: `WD_FIRE`→`WD_OFF` after the last pulse cycle.

A separate two-state key tracker has the states `KEY_WAIT_A` and `KEY_WAIT_B`. It is flushed to `KEY_WAIT_A` while the state machine is in `WD_FIRE`.

Top module: `seq_watchdog`

## Requirements
- R1: After `rst_n` goes low, `wdt_rst` is 0, the block is off and the count is zero.
- R2: While off, no tick, idle or power-down activity produces a pulse. Only a completed key arms the block.
- R3: A write of 0x1E to address 0xA6, followed by the next write to 0xA6 carrying 0xE1, completes the key. Writes to other addresses in between do not affect it. On the second clock edge after the 0xE1 write, the count is zero and the block is running.
- R4: If the write to 0xA6 that follows 0x1E carries any value other than 0xE1 or 0x1E, the partial key is cancelled. A repeated 0x1E keeps the tracker waiting for 0xE1.
- R5: While running, the count advances by one on each counted tick. The counted tick that finds the count at all ones (the 2^CNT_W-th counted tick) makes `wdt_rst` high for exactly PULSE_LEN cycles, starting in the next cycle. After that the block is off.
- R6: A completed key while the block is on clears the count, which restarts the full timeout.
- R7: No write of any value to any address turns the block off once it is on.
- R8: While `pd_mode` is 1, the count is held.
- R9: When `pd_mode` falls while `wake_int_n` is 0, the count stays held until `wake_int_n` is 1.
- R10: In idle (`idle_mode`=1), the count keeps advancing when `idle_freeze`=0 and is held when `idle_freeze`=1.
- R11: Key writes made while the pulse is active are ignored. After the pulse the block is off, and a new full key is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| tick | input | 1 | One-cycle strobe per machine cycle |
| sfr_wr | input | 1 | Special-function register write strobe |
| sfr_addr | input | 8 | Write address |
| sfr_wdata | input | 8 | Write data |
| pd_mode | input | 1 | Core is in power-down |
| idle_mode | input | 1 | Core is in idle |
| idle_freeze | input | 1 | Hold the count during idle when 1 |
| wake_int_n | input | 1 | External wake interrupt line, active low |
| wdt_rst | output | 1 | Reset pulse, active high |

## Verification
The only output is the reset pulse, so every internal fault shows up as a pulse that comes early, late, with the wrong width, or not at all. A count that is off by one moves the pulse edge by one cycle. A lost service delays a trip by a whole timeout, or adds a trip. A wrong hold in power-down or idle shifts the trip by the length of the held interval. The key tracker shows errors only indirectly: a bad arm is visible only when the block trips about 2^CNT_W ticks later. For that reason the bench runs a small counter width, so that each of these faults reaches the pin within about a hundred cycles.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [2:0] {
        WD_OFF,
        WD_RUN,
        WD_PDOWN,
        WD_WAKE,
        WD_FIRE
    } wd_state_e;

    typedef enum logic {
        KEY_WAIT_A,
        KEY_WAIT_B
    } key_state_e;

endpackage

// File: rtl/wdg_key_seq.sv
module wdg_key_seq #(
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  KEY_REG = 8'hA6,
    parameter logic [7:0]  KEY_A   = 8'h1E,
    parameter logic [7:0]  KEY_B   = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              key_done
);
    import wdg_pkg::*;

    key_state_e ks_q, ks_d;
    logic       done_d;
    logic       hit;

    assign hit = wr && (addr == ADDR_W'(KEY_REG));

    always_comb begin
        ks_d   = ks_q;
        done_d = 1'b0;
        if (flush) begin
            ks_d = KEY_WAIT_A;
        end else if (hit) begin
            unique case (ks_q)
                KEY_WAIT_A: ks_d = (wdata == DATA_W'(KEY_A)) ? KEY_WAIT_B : KEY_WAIT_A;
                KEY_WAIT_B: begin
                    if (wdata == DATA_W'(KEY_B)) begin
                        ks_d   = KEY_WAIT_A;
                        done_d = 1'b1;
                    end else if (wdata == DATA_W'(KEY_A)) begin
                        ks_d = KEY_WAIT_B;
                    end else begin
                        ks_d = KEY_WAIT_A;
                    end
                end
                default: ks_d = KEY_WAIT_A;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ks_q     <= KEY_WAIT_A;
            key_done <= 1'b0;
        end else begin
            ks_q     <= ks_d;
            key_done <= done_d;
        end
    end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             at_max
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign at_max = &cnt;

endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
    parameter int PULSE_LEN = 96,
    localparam int PW = $clog2(PULSE_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic last
);
    logic [PW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= PW'(PULSE_LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - PW'(1);
        end
    end

    assign active = (left_q != '0);
    assign last   = (left_q == PW'(1));

endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog #(
    parameter int         CNT_W     = 14,
    parameter int         PULSE_LEN = 96,
    parameter int         ADDR_W    = 8,
    parameter int         DATA_W    = 8,
    parameter logic [7:0] KEY_REG   = 8'hA6,
    parameter logic [7:0] KEY_A     = 8'h1E,
    parameter logic [7:0] KEY_B     = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sfr_wr,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    input  logic              pd_mode,
    input  logic              idle_mode,
    input  logic              idle_freeze,
    input  logic              wake_int_n,
    output logic              wdt_rst
);
    import wdg_pkg::*;

    wd_state_e        state_q, state_d;
    logic             key_done;
    logic [CNT_W-1:0] cnt_q;
    logic             at_max;
    logic             cnt_clr, cnt_inc, trip;
    logic             pulse_last;
    logic             count_ok;

    wdg_key_seq #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W),
        .KEY_REG(KEY_REG), .KEY_A(KEY_A), .KEY_B(KEY_B)
    ) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (state_q == WD_FIRE),
        .wr      (sfr_wr),
        .addr    (sfr_addr),
        .wdata   (sfr_wdata),
        .key_done(key_done)
    );

    wdg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt_q),
        .at_max(at_max)
    );

    wdg_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (trip),
        .active(wdt_rst),
        .last  (pulse_last)
    );

    // a tick counts unless power-down or frozen idle holds it
    assign count_ok = tick && !pd_mode && !(idle_mode && idle_freeze);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    // next state and outputs toward counter and pulse generator
    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        trip    = 1'b0;
        unique case (state_q)
            WD_OFF: begin
                if (key_done) begin
                    state_d = WD_RUN;
                    cnt_clr = 1'b1;
                end
            end
            WD_RUN: begin
                if (key_done) begin
                    cnt_clr = 1'b1;
                end else if (count_ok) begin
                    if (at_max) begin
                        trip    = 1'b1;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                if (trip)         state_d = WD_FIRE;
                else if (pd_mode) state_d = WD_PDOWN;
            end
            WD_PDOWN: begin
                cnt_clr = key_done;
                if (!pd_mode) state_d = wake_int_n ? WD_RUN : WD_WAKE;
            end
            WD_WAKE: begin
                cnt_clr = key_done;
                if (wake_int_n) state_d = WD_RUN;
            end
            WD_FIRE: begin
                if (pulse_last) state_d = WD_OFF;
            end
            default: state_d = WD_OFF;
        endcase
    end

endmodule

// File: rtl/wdg_checks.sv
module wdg_checks #(
    parameter int CNT_W = 14
) (
    input logic                clk,
    input logic                rst_n,
    input wdg_pkg::wd_state_e  st,
    input logic [CNT_W-1:0]    cnt,
    input logic                key_done,
    input logic                pd_mode,
    input logic                idle_mode,
    input logic                idle_freeze,
    input logic                wdt_rst
);
    import wdg_pkg::*;

    AST_OFF_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_OFF && !key_done) |=> (st == WD_OFF)); // R2
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_OFF && key_done) |=> (st == WD_RUN && cnt == '0)); // R3
    AST_PULSE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst) |-> ($past(st) == WD_RUN && st == WD_FIRE)); // R5
    AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_done && st != WD_FIRE) |=> (cnt == '0)); // R6
    AST_NO_SW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_RUN || st == WD_PDOWN || st == WD_WAKE) |=> (st != WD_OFF)); // R7
    AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_PDOWN && !key_done) |=> $stable(cnt)); // R8
    AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_WAKE && !key_done) |=> $stable(cnt)); // R9
    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_RUN && idle_mode && idle_freeze && !key_done) |=> $stable(cnt)); // R10
    AST_PD_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_RUN && pd_mode) |=> !$rose(wdt_rst)); // R8

endmodule

bind seq_watchdog wdg_checks #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (state_q),
    .cnt        (cnt_q),
    .key_done   (key_done),
    .pd_mode    (pd_mode),
    .idle_mode  (idle_mode),
    .idle_freeze(idle_freeze),
    .wdt_rst    (wdt_rst)
);

// File: tb/sim_seq_watchdog.sv
`timescale 1ns/1ps
module sim_seq_watchdog;
    localparam int CW  = 6;
    localparam int PL  = 8;
    localparam int MAXV = (1 << CW) - 1;
    localparam int S_OFF = 0, S_RUN = 1, S_PD = 2, S_WAKE = 3, S_FIRE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic sfr_wr = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic pd_mode = 1'b0, idle_mode = 1'b0, idle_freeze = 1'b0, wake_int_n = 1'b1;
    logic wdt_rst;

    int total = 0, bad = 0;
    string phase = "R1";
    bit done_run = 1'b0;

    always #2 clk = ~clk;

    seq_watchdog #(.CNT_W(CW), .PULSE_LEN(PL)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sfr_wr(sfr_wr),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .pd_mode(pd_mode),
        .idle_mode(idle_mode), .idle_freeze(idle_freeze),
        .wake_int_n(wake_int_n), .wdt_rst(wdt_rst)
    );

    // reference model built from the requirements
    int m_st, m_cnt, m_pl;
    bit m_kb, m_done;

    function automatic bit counts(input bit t, input bit pd, input bit idl, input bit frz);
        return t && !pd && !(idl && frz);
    endfunction

    function automatic bit exp_rst(input int pl);
        return pl != 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = S_OFF; m_cnt = 0; m_pl = 0; m_kb = 0; m_done = 0;
        end else begin
            int n_st, n_cnt, n_pl;
            bit n_kb, n_done, c;
            n_kb = m_kb; n_done = 0;
            if (m_st == S_FIRE) n_kb = 0;
            else if (sfr_wr && sfr_addr == 8'hA6) begin
                if (!m_kb) n_kb = (sfr_wdata == 8'h1E);
                else if (sfr_wdata == 8'hE1) begin n_kb = 0; n_done = 1; end
                else n_kb = (sfr_wdata == 8'h1E);
            end
            c = counts(tick, pd_mode, idle_mode, idle_freeze);
            n_st = m_st; n_cnt = m_cnt; n_pl = m_pl;
            case (m_st)
                S_OFF: if (m_done) begin n_st = S_RUN; n_cnt = 0; end
                S_RUN: begin
                    if (m_done) n_cnt = 0;
                    else if (c) begin
                        if (m_cnt == MAXV) begin n_st = S_FIRE; n_cnt = 0; n_pl = PL; end
                        else n_cnt = m_cnt + 1;
                    end
                    if (n_st != S_FIRE && pd_mode) n_st = S_PD;
                end
                S_PD: begin
                    if (m_done) n_cnt = 0;
                    if (!pd_mode) n_st = wake_int_n ? S_RUN : S_WAKE;
                end
                S_WAKE: begin
                    if (m_done) n_cnt = 0;
                    if (wake_int_n) n_st = S_RUN;
                end
                default: begin
                    n_pl = m_pl - 1;
                    if (m_pl == 1) n_st = S_OFF;
                end
            endcase
            m_st = n_st; m_cnt = n_cnt; m_pl = n_pl; m_kb = n_kb; m_done = n_done;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done_run)
            chk(wdt_rst === exp_rst(m_pl), phase, int'(wdt_rst), int'(exp_rst(m_pl)));
    end

    task automatic wr_sfr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm();
        wr_sfr(8'hA6, 8'h1E);
        wr_sfr(8'hA6, 8'hE1);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        done_run = 1'b1;
        summary();
        $finish;
    end

    initial begin
        int n, w;
        void'($urandom(32'h5eed_0042));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk(wdt_rst == 1'b0, "R1", int'(wdt_rst), 0);

        phase = "R2";
        for (int i = 0; i < 40; i++) begin
            wr_sfr($urandom_range(8'h80, 8'hA5), 8'h1E);
            wr_sfr(8'hA6, 8'hE1);
            idle_mode = $urandom_range(0, 1);
        end
        idle_mode = 1'b0;
        cyc(100);

        // R3 and R5: key across a foreign write, then exact trip timing and width
        phase = "R3";
        wr_sfr(8'hA6, 8'h1E);
        wr_sfr(8'h90, 8'h55);
        wr_sfr(8'hA6, 8'hE1);
        n = 0;
        do begin @(negedge clk); n++; end while (!wdt_rst && n < 500);
        chk(n == MAXV + 2, "R5", n, MAXV + 2);
        w = 0;
        while (wdt_rst && w < 500) begin w++; @(negedge clk); end
        chk(w == PL, "R5", w, PL);
        cyc(100);

        phase = "R4";
        wr_sfr(8'hA6, 8'h1E); wr_sfr(8'hA6, 8'h33); wr_sfr(8'hA6, 8'hE1);
        cyc(100);
        wr_sfr(8'hA6, 8'h1E); wr_sfr(8'hA6, 8'h1E); wr_sfr(8'hA6, 8'hE1);
        phase = "R7";
        wr_sfr(8'hA6, 8'h00); wr_sfr(8'hA6, 8'hFF); wr_sfr(8'hA6, 8'h1E);
        wr_sfr(8'h20, 8'h00);
        cyc(120);

        phase = "R6";
        arm();
        for (int i = 0; i < 6; i++) begin cyc(40); arm(); end
        cyc(120);

        phase = "R8";
        arm(); cyc(20);
        pd_mode = 1'b1; cyc(100);
        pd_mode = 1'b0; cyc(20);
        phase = "R9";
        pd_mode = 1'b1; cyc(10);
        wake_int_n = 1'b0; cyc(5);
        pd_mode = 1'b0; cyc(60);
        wake_int_n = 1'b1; cyc(120);

        phase = "R10";
        arm(); idle_mode = 1'b1; idle_freeze = 1'b0; cyc(30);
        idle_freeze = 1'b1; cyc(100);
        idle_mode = 1'b0; cyc(60);
        idle_freeze = 1'b0;

        phase = "R11";
        arm();
        while (!wdt_rst) @(negedge clk);
        wr_sfr(8'hA6, 8'h1E); wr_sfr(8'hA6, 8'hE1);
        cyc(150);

        phase = "R5";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            tick = ($urandom_range(0, 9) < 7);
            if ($urandom_range(0, 2) == 0) begin
                sfr_wr = 1'b1;
                sfr_addr = ($urandom_range(0, 1) != 0) ? 8'hA6 : 8'($urandom);
                case ($urandom_range(0, 2))
                    0: sfr_wdata = 8'h1E;
                    1: sfr_wdata = 8'hE1;
                    default: sfr_wdata = 8'($urandom);
                endcase
            end else sfr_wr = 1'b0;
            if ($urandom_range(0, 40) == 0) pd_mode = ~pd_mode;
            if ($urandom_range(0, 30) == 0) wake_int_n = ~wake_int_n;
            if ($urandom_range(0, 20) == 0) idle_mode = ~idle_mode;
            if ($urandom_range(0, 50) == 0) idle_freeze = ~idle_freeze;
            if (i == 2000) begin
                phase = "R1";
                rst_n = 1'b0;
                @(negedge clk);
                chk(wdt_rst == 1'b0, "R1", int'(wdt_rst), 0);
                rst_n = 1'b1;
                phase = "R5";
            end
        end
        sfr_wr = 1'b0;
        cyc(2);
        done_run = 1'b1;
        summary();
        $finish;
    end
endmodule